// File: doc/BRIEF.md
# Legacy Interrupt Latch Controller

This block conditions three legacy interrupt sources on behalf of a PC-compatible peripheral bridge. The keyboard and mouse request lines (IRQ1 and IRQ12) are first synchronized to the core clock. Each of them is then either passed straight through or edge-captured. A captured request stays high until software reads the controller data port at I/O address 60h. An active-low floating-point error input can raise an internal IRQ13. A later I/O write to port F0h clears that request and asserts an ignore-numeric-error output. The output stays asserted while the error input remains low.

Three enable bits in a 32-bit configuration register select the modes. The register is written with per-byte enables at dword offset D0h. A decoded I/O-cycle port carries a one-cycle strobe, a direction bit and a 16-bit port address. From it the block detects the data-port read and the error-clear write. Both interfaces are plain control pins with no valid/ready pairing. A strobe or a register write is accepted in the cycle it is high, and the block never applies back-pressure.

Top module: `irq_cond_top`

## Requirements
- R1: While reset is asserted and right after it is released, all four interrupt outputs are 0. The configuration register reads 0000_0004h, which means the mouse latch is enabled and the other two enables are off.
- R2: With the keyboard enable (register bit 0) at 0, kbd_irq_out equals kbd_irq_in delayed by SYNC_STAGES rising clock edges.
- R3: With bit 0 at 1, a rising edge of the synchronized keyboard input sets a latch one edge later. The latch drives kbd_irq_out and stays set until a read strobe to port 0060h.
- R4: The mouse channel behaves like R2 and R3, controlled by register bit 2 and using the same port 0060h read to clear.
- R5: If a new rising edge is detected in the same cycle as the clearing port 0060h read, the latch stays set.
- R6: Clearing a channel's enable bit sends that output back to the bypass value in the same cycle and discards a pending latch. A later re-enable starts with the latch clear.
- R7: With the error enable (register bit 1) at 0, fpu_irq_out and numerr_ignore stay 0 whatever the error input does.
- R8: With bit 1 at 1, a high-to-low transition of the synchronized fpu_err_n sets fpu_irq_out one edge later. fpu_irq_out then holds until a write strobe to port 00F0h. A new transition in the same cycle as that write keeps it set.
- R9: A port 00F0h write while bit 1 is 1 and the synchronized error is low sets numerr_ignore on the next edge. numerr_ignore holds while the synchronized error stays low and falls on the edge after it is seen high.
- R10: A register write at dword address cfg_dw_addr = 34h (byte offset D0h) updates only the byte lanes whose cfg_be bit is 1. The enable bits live in lane 0. Reads at 34h return the enables, with every other bit at 0. Reads at any other address return 0, and writes there change nothing.
- R11: I/O strobes at other ports have no effect on any latch. This includes writes to 0060h and reads of 00F0h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_dw_addr | input | 6 | Configuration dword address (byte offset / 4) |
| cfg_be | input | 4 | Byte-lane enables for a write |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for cfg_dw_addr |
| io_strobe | input | 1 | One-cycle decoded I/O cycle strobe |
| io_write | input | 1 | 1 = I/O write, 0 = I/O read |
| io_addr | input | 16 | I/O port address |
| kbd_irq_in | input | 1 | Keyboard interrupt request (asynchronous) |
| aux_irq_in | input | 1 | Mouse interrupt request (asynchronous) |
| fpu_err_n | input | 1 | Active-low floating-point error (asynchronous) |
| kbd_irq_out | output | 1 | Conditioned keyboard interrupt |
| aux_irq_out | output | 1 | Conditioned mouse interrupt |
| fpu_irq_out | output | 1 | Internal coprocessor error interrupt |
| numerr_ignore | output | 1 | Ignore-numeric-error output, active high |

## Verification
The bench builds the block with SYNC_STAGES = 2, CFG_DW_OFFSET = 34h and the port addresses at their defaults, so the bypass delay is exactly two edges. A bench model that is stepped every edge predicts each output and the readback word. At the default synchronizer depth, a keyboard edge can be placed in the same cycle as a port 0060h read from only a few cycles of directed setup, which brings the R5 and R8 collisions within reach. Long random runs toggle inputs, enables and port strobes at high rates, so enable changes land while latches are set and error writes arrive while the error is in either state.

// File: rtl/irq_cond_pkg.sv
package irq_cond_pkg;
  localparam int CFG_W      = 32;
  localparam int CFG_LANES  = CFG_W / 8;
  localparam int NUM_CH     = 2;
  localparam int CH_KBD     = 0;
  localparam int CH_AUX     = 1;
  localparam int EN_KBD_BIT = 0;
  localparam int EN_FPU_BIT = 1;
  localparam int EN_AUX_BIT = 2;
  localparam logic [CFG_W-1:0] CFG_RESET   = 32'h0000_0004;
  localparam logic [CFG_W-1:0] CFG_RW_MASK =
    (32'd1 << EN_KBD_BIT) | (32'd1 << EN_FPU_BIT) | (32'd1 << EN_AUX_BIT);

  typedef struct packed {
    logic aux_en;
    logic fpu_en;
    logic kbd_en;
  } irq_ctl_t;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic rise,
  output logic fall
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain;
  logic          prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= {STAGES{RST_VAL}};
      prev  <= RST_VAL;
    end else begin
      prev  <= chain[LAST];
      if (STAGES > 1) chain <= {chain[LAST-1:0], din};
      else            chain <= din;
    end
  end

  assign level = chain[LAST];
  assign rise  = chain[LAST] & ~prev;
  assign fall  = ~chain[LAST] & prev;
endmodule

// File: rtl/irq_io_decode.sv
module irq_io_decode #(
  parameter int              ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] DATA_PORT = 16'h0060,
  parameter logic [ADDR_W-1:0] ECLR_PORT = 16'h00F0
) (
  input  logic              io_strobe,
  input  logic              io_write,
  input  logic [ADDR_W-1:0] io_addr,
  output logic              data_rd_hit,
  output logic              eclr_wr_hit
);
  always_comb begin
    data_rd_hit = io_strobe && !io_write && (io_addr == DATA_PORT);
    eclr_wr_hit = io_strobe &&  io_write && (io_addr == ECLR_PORT);
  end
endmodule

// File: rtl/irq_ctl_regs.sv
module irq_ctl_regs
  import irq_cond_pkg::*;
#(
  parameter int          AW        = 6,
  parameter logic [AW-1:0] DW_OFFSET = 6'h34
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr,
  input  logic [AW-1:0]        cfg_dw_addr,
  input  logic [CFG_LANES-1:0] cfg_be,
  input  logic [CFG_W-1:0]     cfg_wdata,
  output logic [CFG_W-1:0]     cfg_rdata,
  output irq_ctl_t             ctl
);
  logic             hit;
  logic [CFG_W-1:0] store;

  assign hit = (cfg_dw_addr == DW_OFFSET);

  for (genvar g = 0; g < CFG_LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        store[g*8 +: 8] <= CFG_RESET[g*8 +: 8] & CFG_RW_MASK[g*8 +: 8];
      else if (cfg_wr && hit && cfg_be[g])
        store[g*8 +: 8] <= cfg_wdata[g*8 +: 8] & CFG_RW_MASK[g*8 +: 8];
    end
  end

  always_comb begin
    cfg_rdata  = hit ? (store & CFG_RW_MASK) : '0;
    ctl.kbd_en = store[EN_KBD_BIT];
    ctl.fpu_en = store[EN_FPU_BIT];
    ctl.aux_en = store[EN_AUX_BIT];
  end
endmodule

// File: rtl/irq_hold_ch.sv
module irq_hold_ch (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic level,
  input  logic rise,
  input  logic clr,
  output logic out
);
  logic held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   held <= 1'b0;
    else if (!en) held <= 1'b0;
    else          held <= rise | (held & ~clr);
  end

  assign out = en ? held : level;
endmodule

// File: rtl/irq_fpu_err.sv
module irq_fpu_err (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic err_lvl,
  input  logic err_fall,
  input  logic eclr,
  output logic irq_out,
  output logic ign_out
);
  logic irq_q;
  logic ign_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      ign_q <= 1'b0;
    end else if (!en) begin
      irq_q <= 1'b0;
      ign_q <= 1'b0;
    end else begin
      irq_q <= err_fall | (irq_q & ~eclr);
      if (err_lvl) ign_q <= 1'b0;
      else         ign_q <= ign_q | eclr;
    end
  end

  assign irq_out = irq_q & en;
  assign ign_out = ign_q & en;
endmodule

// File: rtl/irq_cond_top.sv
module irq_cond_top
  import irq_cond_pkg::*;
#(
  parameter int              SYNC_STAGES   = 2,
  parameter int              IO_AW         = 16,
  parameter logic [IO_AW-1:0] DATA_PORT    = 16'h0060,
  parameter logic [IO_AW-1:0] ECLR_PORT    = 16'h00F0,
  parameter logic [5:0]      CFG_DW_OFFSET = 6'h34
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [5:0]       cfg_dw_addr,
  input  logic [3:0]       cfg_be,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata,
  input  logic             io_strobe,
  input  logic             io_write,
  input  logic [IO_AW-1:0] io_addr,
  input  logic             kbd_irq_in,
  input  logic             aux_irq_in,
  input  logic             fpu_err_n,
  output logic             kbd_irq_out,
  output logic             aux_irq_out,
  output logic             fpu_irq_out,
  output logic             numerr_ignore
);
  irq_ctl_t          ctl;
  logic              rd_hit;
  logic              wr_hit;
  logic [NUM_CH-1:0] ch_in;
  logic [NUM_CH-1:0] ch_en;
  logic [NUM_CH-1:0] ch_lvl;
  logic [NUM_CH-1:0] ch_rise;
  logic [NUM_CH-1:0] ch_fall;
  logic [NUM_CH-1:0] ch_out;
  logic              err_lvl;
  logic              err_fall;
  logic              err_rise;

  irq_ctl_regs #(.AW(6), .DW_OFFSET(CFG_DW_OFFSET)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_dw_addr(cfg_dw_addr),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .ctl(ctl)
  );

  irq_io_decode #(.ADDR_W(IO_AW), .DATA_PORT(DATA_PORT), .ECLR_PORT(ECLR_PORT)) u_dec (
    .io_strobe(io_strobe), .io_write(io_write), .io_addr(io_addr),
    .data_rd_hit(rd_hit), .eclr_wr_hit(wr_hit)
  );

  assign ch_in[CH_KBD] = kbd_irq_in;
  assign ch_in[CH_AUX] = aux_irq_in;
  assign ch_en[CH_KBD] = ctl.kbd_en;
  assign ch_en[CH_AUX] = ctl.aux_en;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    irq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(ch_in[c]),
      .level(ch_lvl[c]), .rise(ch_rise[c]), .fall(ch_fall[c])
    );
    irq_hold_ch u_hold (
      .clk(clk), .rst_n(rst_n), .en(ch_en[c]), .level(ch_lvl[c]),
      .rise(ch_rise[c]), .clr(rd_hit), .out(ch_out[c])
    );
  end

  irq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_err_sync (
    .clk(clk), .rst_n(rst_n), .din(fpu_err_n),
    .level(err_lvl), .rise(err_rise), .fall(err_fall)
  );

  irq_fpu_err u_fpu (
    .clk(clk), .rst_n(rst_n), .en(ctl.fpu_en), .err_lvl(err_lvl),
    .err_fall(err_fall), .eclr(wr_hit), .irq_out(fpu_irq_out), .ign_out(numerr_ignore)
  );

  assign kbd_irq_out = ch_out[CH_KBD];
  assign aux_irq_out = ch_out[CH_AUX];
endmodule

// File: rtl/irq_cond_chk.sv
module irq_cond_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] ch_en,
  input logic [1:0] ch_rise,
  input logic [1:0] ch_out,
  input logic       rd_hit,
  input logic       wr_hit,
  input logic       fpu_en,
  input logic       err_lvl,
  input logic       err_fall,
  input logic       fpu_irq_out,
  input logic       numerr_ignore
);
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_quiet_r1: assert (ch_out == 2'b00 && !fpu_irq_out && !numerr_ignore)
        else $error("outputs active during reset");
    end
  end

  p_kbd_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_en[0] && ch_out[0] && !rd_hit) |=> (ch_out[0] || !ch_en[0]));

  p_kbd_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_en[0] && rd_hit && !ch_rise[0]) |=> (!ch_out[0] || !ch_en[0]));

  p_aux_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_en[1] && ch_out[1] && !rd_hit) |=> (ch_out[1] || !ch_en[1]));

  p_kbd_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_en[0] && ch_rise[0]) |=> (ch_out[0] || !ch_en[0]));

  p_aux_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_en[1] && ch_rise[1]) |=> (ch_out[1] || !ch_en[1]));

  p_fpu_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !fpu_en |=> (!fpu_irq_out && !numerr_ignore));

  p_fpu_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fpu_en && err_fall) |=> (fpu_irq_out || !fpu_en));

  p_fpu_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fpu_irq_out && !wr_hit) |=> (fpu_irq_out || !fpu_en));

  p_ign_needs_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    numerr_ignore |-> $past(!err_lvl));
endmodule

bind irq_cond_top irq_cond_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .ch_rise(ch_rise), .ch_out(ch_out),
  .rd_hit(rd_hit), .wr_hit(wr_hit), .fpu_en(ctl.fpu_en), .err_lvl(err_lvl),
  .err_fall(err_fall), .fpu_irq_out(fpu_irq_out), .numerr_ignore(numerr_ignore)
);

// File: tb/sim_irq_cond_top.sv
`timescale 1ns/1ps
module sim_irq_cond_top;
  localparam int STG = 2;
  localparam logic [5:0] CFG_DW = 6'h34;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0;
  logic [5:0] cfg_dw_addr = CFG_DW;
  logic [3:0] cfg_be = 4'h0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic io_strobe = 1'b0, io_write = 1'b0;
  logic [15:0] io_addr = '0;
  logic kbd_irq_in = 1'b0, aux_irq_in = 1'b0, fpu_err_n = 1'b1;
  logic kbd_irq_out, aux_irq_out, fpu_irq_out, numerr_ignore;

  int vectors = 0;
  int fails = 0;
  string phase = "R1";

  always #2.5 clk = ~clk;

  irq_cond_top #(.SYNC_STAGES(STG), .CFG_DW_OFFSET(CFG_DW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_dw_addr(cfg_dw_addr),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .io_strobe(io_strobe), .io_write(io_write), .io_addr(io_addr),
    .kbd_irq_in(kbd_irq_in), .aux_irq_in(aux_irq_in), .fpu_err_n(fpu_err_n),
    .kbd_irq_out(kbd_irq_out), .aux_irq_out(aux_irq_out),
    .fpu_irq_out(fpu_irq_out), .numerr_ignore(numerr_ignore)
  );

  // Bench model: enables {aux(bit2), fpu(bit1), kbd(bit0)}
  logic [2:0]     m_en;
  logic [STG-1:0] m_pipe [2];
  logic           m_prev [2];
  logic           m_lat  [2];
  logic [STG-1:0] m_fpipe;
  logic           m_fprev, m_irq, m_ign;

  function automatic logic m_ch_en(input int c);
    return (c == 0) ? m_en[0] : m_en[2];
  endfunction

  function automatic logic m_ch_out(input int c);
    return m_ch_en(c) ? m_lat[c] : m_pipe[c][STG-1];
  endfunction

  function automatic logic [31:0] m_rdata(input logic [5:0] a);
    return (a == CFG_DW) ? {29'd0, m_en} : 32'd0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 3'b100;
      for (int c = 0; c < 2; c++) begin
        m_pipe[c] = '0; m_prev[c] = 1'b0; m_lat[c] = 1'b0;
      end
      m_fpipe = '1; m_fprev = 1'b1; m_irq = 1'b0; m_ign = 1'b0;
    end else begin
      logic rd60, wrf0, lvl, fl;
      logic [1:0] ins;
      rd60 = io_strobe && !io_write && io_addr == 16'h0060;
      wrf0 = io_strobe && io_write && io_addr == 16'h00F0;
      ins = {aux_irq_in, kbd_irq_in};
      for (int c = 0; c < 2; c++) begin
        lvl = m_pipe[c][STG-1];
        if (!m_ch_en(c)) m_lat[c] = 1'b0;
        else m_lat[c] = (lvl & ~m_prev[c]) | (m_lat[c] & ~rd60);
        m_prev[c] = lvl;
        m_pipe[c] = {m_pipe[c][STG-2:0], ins[c]};
      end
      fl = m_fpipe[STG-1];
      if (!m_en[1]) begin
        m_irq = 1'b0; m_ign = 1'b0;
      end else begin
        m_irq = (~fl & m_fprev) | (m_irq & ~wrf0);
        m_ign = fl ? 1'b0 : (m_ign | wrf0);
      end
      m_fprev = fl;
      m_fpipe = {m_fpipe[STG-2:0], fpu_err_n};
      if (cfg_wr && cfg_dw_addr == CFG_DW && cfg_be[0]) m_en = cfg_wdata[2:0];
    end
  end

  task automatic cmp1(input string what, input string tag, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s [%s] %s act=%0b exp=%0b at %0t", tag, phase, what, act, exp, $time);
    end
  endtask

  task automatic check_all();
    vectors++;
    if (cfg_rdata !== m_rdata(cfg_dw_addr)) begin
      fails++;
      $display("FAIL R10 [%s] cfg_rdata act=%h exp=%h", phase, cfg_rdata, m_rdata(cfg_dw_addr));
    end
    cmp1("kbd_irq_out", "R2 R3", kbd_irq_out, m_ch_out(0));
    cmp1("aux_irq_out", "R4", aux_irq_out, m_ch_out(1));
    cmp1("fpu_irq_out", "R8", fpu_irq_out, m_irq & m_en[1]);
    cmp1("numerr_ignore", "R9", numerr_ignore, m_ign & m_en[1]);
  endtask

  task automatic step();
    @(negedge clk);
    check_all();
    cfg_wr = 1'b0; io_strobe = 1'b0;
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic cfg_write(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d);
    cfg_wr = 1'b1; cfg_dw_addr = a; cfg_be = be; cfg_wdata = d;
    step();
    cfg_dw_addr = CFG_DW;
  endtask

  task automatic io_op(input logic wr, input logic [15:0] a);
    io_strobe = 1'b1; io_write = wr; io_addr = a;
    step();
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h1D2C_3B4A));
    repeat (3) @(negedge clk);
    // R1: reset values, then release
    check_all();
    cmp1("reset rdata bit2", "R1", cfg_rdata[2], 1'b1);
    rst_n = 1'b1;
    steps(3);

    phase = "R10";
    cfg_write(CFG_DW, 4'b1110, 32'hFFFF_FFFF);
    steps(1);
    cfg_write(CFG_DW, 4'b0001, 32'hFFFF_FF03);
    steps(1);
    cfg_write(6'h10, 4'hF, 32'h0000_0000);
    cfg_dw_addr = 6'h10; steps(1); cfg_dw_addr = CFG_DW;
    steps(1);
    cmp1("rdata after lane0 write", "R10", cfg_rdata == 32'h3, 1'b1);

    phase = "R2";
    cfg_write(CFG_DW, 4'h1, 32'h0);
    kbd_irq_in = 1'b1; steps(4);
    kbd_irq_in = 1'b0; steps(4);

    phase = "R3";
    cfg_write(CFG_DW, 4'h1, 32'h1);
    kbd_irq_in = 1'b1; steps(1); kbd_irq_in = 1'b0;
    steps(6);
    cmp1("kbd held", "R3", kbd_irq_out, 1'b1);
    io_op(1'b0, 16'h0060);
    steps(1);
    cmp1("kbd cleared", "R3", kbd_irq_out, 1'b0);

    phase = "R4";
    cfg_write(CFG_DW, 4'h1, 32'h4);
    aux_irq_in = 1'b1; steps(3); aux_irq_in = 1'b0; steps(4);
    cmp1("aux held", "R4", aux_irq_out, 1'b1);
    io_op(1'b0, 16'h0060); steps(1);

    phase = "R5";
    cfg_write(CFG_DW, 4'h1, 32'h5);
    kbd_irq_in = 1'b1; steps(1); kbd_irq_in = 1'b0;
    steps(5);
    kbd_irq_in = 1'b1; steps(1); kbd_irq_in = 1'b0;
    steps(1);
    io_op(1'b0, 16'h0060);
    steps(1);
    cmp1("kbd kept on collision", "R5", kbd_irq_out, 1'b1);

    phase = "R6";
    cfg_write(CFG_DW, 4'h1, 32'h4);
    cmp1("kbd bypass after disable", "R6", kbd_irq_out, 1'b0);
    cfg_write(CFG_DW, 4'h1, 32'h5);
    steps(2);
    cmp1("kbd clear after re-enable", "R6", kbd_irq_out, 1'b0);

    phase = "R11";
    aux_irq_in = 1'b1; steps(4); aux_irq_in = 1'b0; steps(2);
    io_op(1'b1, 16'h0060);
    io_op(1'b0, 16'h0061);
    io_op(1'b0, 16'h00F0);
    io_op(1'b0, 16'h0160);
    cmp1("aux kept after other ports", "R11", aux_irq_out, 1'b1);
    io_op(1'b0, 16'h0060); steps(1);

    phase = "R7";
    cfg_write(CFG_DW, 4'h1, 32'h0);
    fpu_err_n = 1'b0; steps(4);
    io_op(1'b1, 16'h00F0); steps(2);
    cmp1("fpu irq off", "R7", fpu_irq_out, 1'b0);
    cmp1("ignore off", "R7", numerr_ignore, 1'b0);
    fpu_err_n = 1'b1; steps(4);

    phase = "R8";
    cfg_write(CFG_DW, 4'h1, 32'h2);
    fpu_err_n = 1'b0; steps(5);
    cmp1("fpu irq set", "R8", fpu_irq_out, 1'b1);
    io_op(1'b1, 16'h00F0);
    phase = "R9";
    steps(1);
    cmp1("fpu irq cleared", "R8", fpu_irq_out, 1'b0);
    cmp1("ignore set", "R9", numerr_ignore, 1'b1);
    steps(3);
    fpu_err_n = 1'b1; steps(4);
    cmp1("ignore dropped", "R9", numerr_ignore, 1'b0);

    phase = "RND";
    for (int i = 0; i < 30000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if ($urandom_range(0, 9) == 0) kbd_irq_in = ~kbd_irq_in;
      if ($urandom_range(0, 9) == 0) aux_irq_in = ~aux_irq_in;
      if ($urandom_range(0, 15) == 0) fpu_err_n = ~fpu_err_n;
      cfg_dw_addr = ($urandom_range(0, 7) == 0) ? 6'($urandom) : CFG_DW;
      if (r < 4) begin
        cfg_wr = 1'b1; cfg_be = 4'($urandom); cfg_wdata = $urandom;
      end
      if (r >= 20 && r < 45) begin
        io_strobe = 1'b1; io_write = 1'($urandom);
        case ($urandom_range(0, 3))
          0: io_addr = 16'h0060;
          1: io_addr = 16'h00F0;
          2: io_addr = 16'h0064;
          default: io_addr = 16'($urandom);
        endcase
      end
      step();
    end
    finish_run();
  end
endmodule